// File: doc/BRIEF.md
# SPI Controller with Single-Wire Data Option

This block is an 8-bit SPI shift engine that works as bus master or as slave. As master it generates SCK from the system clock through a divider set by a prescale field and an exponent field. It can lower its slave-select output by itself for the length of each transfer. It also watches its slave-select input for a competing master. As slave it takes SCK and slave select from the pins, synchronises them, and shifts data on the edges it detects.

A routing stage places the serial data on the pins. In normal mode MOSI and MISO are separate wires. In single-wire mode one pin carries both directions: MOSI for a master and MISO for a slave. A control bit then decides whether that pin is driven or read. Each pin has its own output value and output enable, so the pad ring owns the actual tristate. The bus interface is a set of static control inputs, a one-cycle byte write strobe, a received-byte register and a one-cycle completion pulse.

SPI timing is fixed: SCK idles low, data is sampled on the rising edge and shifted on the falling edge, MSB first.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: With prescale P and exponent E, master SCK stays high for exactly H = (P+1)*2^E system clocks and low for H clocks between rising edges. The full bit period is therefore (P+1)*2^(E+1) clocks.
- R2: The divider counts only while the block is an active master in a transfer. While idle, SCK stays low. After a write strobe is accepted in an idle master, the first rising SCK edge comes exactly H clocks later.
- R3: A transfer moves 8 bits MSB first in both directions. The received byte appears on rd_data, and xfer_done pulses for one cycle on the clock where SCK returns low after the eighth sampling edge.
- R4: When master, ss_auto and fault_en are all set, ss_oe is 1 and ss_o is 0 for the whole transfer and 1 when idle. In every other case ss_oe is 0.
- R5: A master with fault_en=1 and ss_auto=0 that sees ss_i low (after synchronisation) sets fault_flag and becomes a slave, with sck_oe and mosi_oe at 0. The flag clears when cfg_enable or cfg_master is 0.
- R6: ss_i low raises no fault while ss_auto is set, nor while fault_en is 0. The block stays master.
- R7: In single-wire master mode, data leaves on mosi_o and enters on mosi_i, mosi_oe equals cfg_one_wire_drive, miso_oe is 0, and miso_i is ignored.
- R8: In single-wire slave mode, data leaves on miso_o and enters on miso_i. miso_oe equals cfg_one_wire_drive while selected, and mosi_oe is 0.
- R9: In normal slave mode, SCK, ss_i and mosi_i are synchronised. A byte written while not selected is shifted out on miso_o. mosi_i is sampled on each rising SCK while selected, and miso_oe is 1 only while ss_i is low.
- R10: In normal master mode, sck_oe and mosi_oe are 1, miso_oe is 0, and received bits come from miso_i.
- R11: With cfg_enable=0, all four output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable |
| cfg_master | input | 1 | 1 requests master role |
| cfg_ss_auto | input | 1 | Automatic slave-select drive request |
| cfg_fault_en | input | 1 | Mode-fault detection enable |
| cfg_one_wire | input | 1 | Single-wire data mode |
| cfg_one_wire_drive | input | 1 | Single-wire pin drives (1) or reads (0) |
| cfg_prescale | input | PRE_W (3) | Divider prescale P |
| cfg_exponent | input | EXP_W (3) | Divider exponent E |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | DATA_W (8) | Byte to transmit |
| rd_data | output | DATA_W (8) | Last received byte |
| xfer_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| fault_flag | output | 1 | Mode fault seen |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Slave-select pin input |
| ss_o | output | 1 | Slave-select pin output |
| ss_oe | output | 1 | Slave-select output enable |

## Verification
A wrong divider count shows on the first SCK edge: its pulse width differs from H within one half period of the write. A stuck or skipped bit counter moves the xfer_done pulse away from the sixteenth SCK edge and garbles rd_data within one byte. Routing faults show at once as wrong output enables or as data taken from the wrong pin. A fault flag that fails to set or clear shows at the pins within three clocks of ss_i falling.

// File: rtl/spi_bd_pkg.sv
package spi_bd_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int PRE_W_DEF  = 3;
    localparam int EXP_W_DEF  = 3;

    typedef enum logic [1:0] {
        ROLE_OFF    = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_e;

    typedef struct packed {
        logic enable;
        logic master;
        logic ss_auto;
        logic fault_en;
        logic one_wire;
        logic one_wire_drive;
    } ctl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic role_e pick_role(input ctl_t c, input logic fault);
        if (!c.enable)               return ROLE_OFF;
        else if (c.master && !fault) return ROLE_MASTER;
        else                         return ROLE_SLAVE;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int            W       = 4,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= d_i;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int PRE_W = 3,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [PRE_W-1:0] presc_i,
    input  logic [EXP_W-1:0] expo_i,
    output logic             tick_o
);
    localparam int HALF_W = PRE_W + (1 << EXP_W);

    logic [HALF_W-1:0] half_len;
    logic [HALF_W-1:0] cnt_q;
    logic [PRE_W:0]    presc_p1;

    assign presc_p1 = {1'b0, presc_i} + {{PRE_W{1'b0}}, 1'b1};
    assign half_len = {{(HALF_W-PRE_W-1){1'b0}}, presc_p1} << expo_i;
    assign tick_o   = run_i && (cnt_q == half_len - {{(HALF_W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else if (tick_o)   cnt_q <= '0;
        else               cnt_q <= cnt_q + {{(HALF_W-1){1'b0}}, 1'b1};
    end

    // R2: a stopped divider restarts from zero so the first half period is full length
    a_r2_restart_full: assert property (@(posedge clk) disable iff (rst)
        (!run_i ##1 run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_bd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  role_e             role_i,
    input  logic              abort_i,
    input  logic              tick_i,
    input  edge_t             s_edge_i,
    input  logic              s_sel_i,
    input  logic              din_i,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              dout_o,
    output logic              sck_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W-1);

    logic [DATA_W-1:0] shreg_q, rd_q;
    logic [CNT_W-1:0]  bit_q;
    logic              rx_q, sck_q, busy_q, done_q;
    logic [DATA_W-1:0] shifted;

    assign shifted = {shreg_q[DATA_W-2:0], rx_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            rd_q    <= '0;
            bit_q   <= '0;
            rx_q    <= 1'b0;
            sck_q   <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (role_i == ROLE_OFF || abort_i) begin
                busy_q <= 1'b0;
                sck_q  <= 1'b0;
                bit_q  <= '0;
            end else if (role_i == ROLE_MASTER) begin
                if (!busy_q) begin
                    if (wr_valid_i) begin
                        busy_q  <= 1'b1;
                        shreg_q <= wr_data_i;
                        bit_q   <= '0;
                        sck_q   <= 1'b0;
                    end
                end else if (tick_i) begin
                    sck_q <= ~sck_q;
                    if (!sck_q) begin
                        rx_q <= din_i;
                    end else begin
                        shreg_q <= shifted;
                        if (bit_q == LAST) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                            rd_q   <= shifted;
                            bit_q  <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
            end else begin
                sck_q <= 1'b0;
                if (!s_sel_i) begin
                    busy_q <= 1'b0;
                    bit_q  <= '0;
                    if (wr_valid_i) shreg_q <= wr_data_i;
                end else begin
                    if (s_edge_i.rise) begin
                        rx_q   <= din_i;
                        busy_q <= 1'b1;
                    end
                    if (s_edge_i.fall && busy_q) begin
                        shreg_q <= shifted;
                        if (bit_q == LAST) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                            rd_q   <= shifted;
                            bit_q  <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign dout_o    = shreg_q[DATA_W-1];
    assign sck_o     = sck_q;
    assign busy_o    = busy_q;
    assign rd_data_o = rd_q;
    assign done_o    = done_q;

    // R3: completion is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R1: SCK only moves on a divider tick
    a_r1_sck_hold: assert property (@(posedge clk) disable iff (rst)
        (role_i == ROLE_MASTER && busy_q && !tick_i && !abort_i) |=> $stable(sck_q));
endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route
    import spi_bd_pkg::*;
(
    input  role_e role_i,
    input  ctl_t  ctl_i,
    input  logic  busy_i,
    input  logic  sck_i,
    input  logic  dout_i,
    input  logic  s_sel_i,
    input  logic  mosi_raw_i,
    input  logic  miso_raw_i,
    input  logic  mosi_sync_i,
    input  logic  miso_sync_i,
    output logic  din_o,
    output logic  sck_o,
    output logic  sck_oe,
    output logic  mosi_o,
    output logic  mosi_oe,
    output logic  miso_o,
    output logic  miso_oe,
    output logic  ss_o,
    output logic  ss_oe
);
    always_comb begin
        din_o   = 1'b0;
        sck_o   = 1'b0;
        sck_oe  = 1'b0;
        mosi_o  = dout_i;
        mosi_oe = 1'b0;
        miso_o  = dout_i;
        miso_oe = 1'b0;
        ss_o    = 1'b1;
        ss_oe   = 1'b0;
        unique case (role_i)
            ROLE_MASTER: begin
                sck_o  = sck_i;
                sck_oe = 1'b1;
                if (ctl_i.one_wire) begin
                    mosi_oe = ctl_i.one_wire_drive;
                    din_o   = mosi_raw_i;
                end else begin
                    mosi_oe = 1'b1;
                    din_o   = miso_raw_i;
                end
                if (ctl_i.ss_auto && ctl_i.fault_en) begin
                    ss_oe = 1'b1;
                    ss_o  = !busy_i;
                end
            end
            ROLE_SLAVE: begin
                if (ctl_i.one_wire) begin
                    miso_oe = ctl_i.one_wire_drive && s_sel_i;
                    din_o   = miso_sync_i;
                end else begin
                    miso_oe = s_sel_i;
                    din_o   = mosi_sync_i;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
    import spi_bd_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int PRE_W  = PRE_W_DEF,
    parameter int EXP_W  = EXP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_master,
    input  logic              cfg_ss_auto,
    input  logic              cfg_fault_en,
    input  logic              cfg_one_wire,
    input  logic              cfg_one_wire_drive,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [EXP_W-1:0]  cfg_exponent,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_done,
    output logic              busy,
    output logic              fault_flag,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe
);
    ctl_t  ctl;
    role_e role;
    edge_t s_edge;
    logic  fault_q, fault_set;
    logic  ss_s, sck_s, mosi_s, miso_s, sck_prev_q;
    logic  baud_tick, eng_busy, eng_sck, eng_dout, din, s_sel;

    assign ctl = '{enable: cfg_enable, master: cfg_master, ss_auto: cfg_ss_auto,
                   fault_en: cfg_fault_en, one_wire: cfg_one_wire,
                   one_wire_drive: cfg_one_wire_drive};

    spi_in_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1000)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({ss_i, sck_i, mosi_i, miso_i}),
        .q_o ({ss_s, sck_s, mosi_s, miso_s})
    );

    assign role      = pick_role(ctl, fault_q);
    assign fault_set = (role == ROLE_MASTER) && ctl.fault_en && !ctl.ss_auto && !ss_s;
    assign s_sel     = (role == ROLE_SLAVE) && !ss_s;
    assign s_edge    = '{rise: sck_s && !sck_prev_q, fall: !sck_s && sck_prev_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q    <= 1'b0;
            sck_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            if (!ctl.enable || !ctl.master) fault_q <= 1'b0;
            else if (fault_set)             fault_q <= 1'b1;
        end
    end

    spi_baud_gen #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run_i   ((role == ROLE_MASTER) && eng_busy),
        .presc_i (cfg_prescale),
        .expo_i  (cfg_exponent),
        .tick_o  (baud_tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .role_i     (role),
        .abort_i    (fault_set),
        .tick_i     (baud_tick),
        .s_edge_i   (s_edge),
        .s_sel_i    (s_sel),
        .din_i      (din),
        .wr_valid_i (wr_valid),
        .wr_data_i  (wr_data),
        .dout_o     (eng_dout),
        .sck_o      (eng_sck),
        .busy_o     (eng_busy),
        .rd_data_o  (rd_data),
        .done_o     (xfer_done)
    );

    spi_pin_route u_route (
        .role_i      (role),
        .ctl_i       (ctl),
        .busy_i      (eng_busy),
        .sck_i       (eng_sck),
        .dout_i      (eng_dout),
        .s_sel_i     (s_sel),
        .mosi_raw_i  (mosi_i),
        .miso_raw_i  (miso_i),
        .mosi_sync_i (mosi_s),
        .miso_sync_i (miso_s),
        .din_o       (din),
        .sck_o       (sck_o),
        .sck_oe      (sck_oe),
        .mosi_o      (mosi_o),
        .mosi_oe     (mosi_oe),
        .miso_o      (miso_o),
        .miso_oe     (miso_oe),
        .ss_o        (ss_o),
        .ss_oe       (ss_oe)
    );

    assign busy       = eng_busy;
    assign fault_flag = fault_q;

    // R2: no divider tick outside a transfer
    a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> !baud_tick);

    // R4: automatic select stays low while the engine is busy
    a_r4_ss_low_busy: assert property (@(posedge clk) disable iff (rst)
        (ss_oe && eng_busy) |-> !ss_o);

    // R5: a faulted master releases clock and data
    a_r5_fault_release: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> (!sck_oe && !mosi_oe));

    // R6: automatic select suppresses fault detection
    a_r6_no_fault_auto: assert property (@(posedge clk) disable iff (rst)
        (!fault_q && cfg_ss_auto) |=> !fault_q);

    // R7: single-wire master leaves MISO free
    a_r7_master_miso_free: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_MASTER && cfg_one_wire) |-> !miso_oe);

    // R8: slave never drives MOSI or SCK
    a_r8_slave_mosi_free: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_SLAVE) |-> (!mosi_oe && !sck_oe));

    // R11: disabled block releases every pin
    a_r11_all_released: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |-> !(sck_oe || mosi_oe || miso_oe || ss_oe));
endmodule

// File: tb/spi_duplex_ctrl_tb.sv
`timescale 1ns/1ps
module spi_duplex_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 0, cfg_master = 0, cfg_ss_auto = 0, cfg_fault_en = 0;
    logic       cfg_one_wire = 0, cfg_one_wire_drive = 0;
    logic [2:0] cfg_prescale = 0, cfg_exponent = 0;
    logic       wr_valid = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       xfer_done, busy, fault_flag;
    logic       sck_i = 0, mosi_i = 0, miso_i = 0, ss_i = 1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    spi_duplex_ctrl u_dut (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_ss_auto(cfg_ss_auto),
        .cfg_fault_en(cfg_fault_en), .cfg_one_wire(cfg_one_wire),
        .cfg_one_wire_drive(cfg_one_wire_drive), .cfg_prescale(cfg_prescale),
        .cfg_exponent(cfg_exponent), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_data(rd_data), .xfer_done(xfer_done), .busy(busy), .fault_flag(fault_flag),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic set_din(input bit one_wire, input bit v);
        if (one_wire) begin mosi_i = v; miso_i = ~v; end
        else          begin miso_i = v; mosi_i = ~v; end
    endtask

    // master transfer; bench plays the remote slave
    task automatic run_master(input logic [7:0] tx, input logic [7:0] resp,
                              input int h, input bit auto_ss, input bit one_wire);
        int k = 0, first = -1, run = 0, bad = 0, nrise = 0, ss_bad = 0;
        bit prev = 0, s, done_seen = 0, idle_bad = 0;
        logic [7:0] cap = 0;
        set_din(one_wire, resp[7]);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (sck_o !== 1'b0) idle_bad = 1;
            if (auto_ss && ss_o !== 1'b1) idle_bad = 1;
        end
        check(!idle_bad, "R2 idle SCK low / R4 SS high", idle_bad, 0);
        wr_data = tx; wr_valid = 1;
        @(negedge clk);
        wr_valid = 0;
        while (!done_seen && k < 16 * h + 20) begin
            @(negedge clk);
            k++;
            s = sck_o;
            if (s && !prev) begin
                nrise++;
                if (first < 0) first = k;
                else if (run != h) bad++;
                cap = {cap[6:0], mosi_o};
                run = 1;
            end else if (!s && prev) begin
                if (run != h) bad++;
                if (nrise < 8) set_din(one_wire, resp[7 - nrise]);
                run = 1;
            end else begin
                run++;
            end
            if (auto_ss && s && ss_o !== 1'b0) ss_bad++;
            if (xfer_done) done_seen = 1;
            prev = s;
        end
        check(first == h, "R2 first edge latency", first, h);
        check(bad == 0, "R1 half-period width", bad, 0);
        check(done_seen && nrise == 8 && !s, "R3 done after 8 edges, SCK low", nrise, 8);
        check(cap == tx, "R3 transmitted byte MSB first", cap, tx);
        check(rd_data == resp, "R3/R7/R10 received byte", rd_data, resp);
        if (auto_ss) begin
            check(ss_bad == 0 && ss_oe == 1'b1, "R4 SS low during transfer", ss_bad, 0);
            check(ss_o == 1'b1, "R4 SS high after done", ss_o, 1);
        end else begin
            check(ss_oe == 1'b0, "R4 SS not driven", ss_oe, 0);
        end
        @(negedge clk);
        check(xfer_done == 1'b0, "R3 done single cycle", xfer_done, 0);
    endtask

    // slave transfer; bench plays the remote master
    task automatic run_slave(input logic [7:0] pre, input logic [7:0] send,
                             input bit one_wire, input bit drive);
        logic [7:0] cap = 0;
        bit done_seen = 0;
        ss_i = 1;
        @(negedge clk);
        check(miso_oe == 0 && sck_oe == 0 && mosi_oe == 0, "R9 released while deselected",
              {sck_oe, mosi_oe, miso_oe}, 0);
        wr_data = pre; wr_valid = 1;
        @(negedge clk);
        wr_valid = 0;
        ss_i = 0;
        if (one_wire) begin miso_i = send[7]; mosi_i = ~send[7]; end
        else          begin mosi_i = send[7]; miso_i = ~send[7]; end
        for (int b = 0; b < 8; b++) begin
            repeat (6) @(negedge clk);
            cap = {cap[6:0], miso_o};
            if (b == 0) begin
                if (one_wire)
                    check(miso_oe == drive && mosi_oe == 0, "R8 single-wire slave enables", miso_oe, drive);
                else
                    check(miso_oe == 1 && mosi_oe == 0, "R9 MISO driven while selected", miso_oe, 1);
            end
            sck_i = 1;
            repeat (6) @(negedge clk);
            sck_i = 0;
            if (b < 7) begin
                if (one_wire) begin miso_i = send[6 - b]; mosi_i = ~send[6 - b]; end
                else          begin mosi_i = send[6 - b]; miso_i = ~send[6 - b]; end
            end
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (xfer_done) done_seen = 1;
        end
        check(done_seen, "R9 slave done", done_seen, 1);
        check(cap == pre, "R9/R8 slave shifted out preload", cap, pre);
        check(rd_data == send, "R9/R8 slave received byte", rd_data, send);
        ss_i = 1;
        repeat (4) @(negedge clk);
        check(miso_oe == 0, "R9 MISO released after deselect", miso_oe, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        check(!sck_oe && !mosi_oe && !miso_oe && !ss_oe, "R11 reset/disabled enables",
              {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
        check(!xfer_done && !fault_flag && !busy && rd_data == 0, "reset outputs", rd_data, 0);

        // normal master sweep over prescale and exponent
        cfg_enable = 1; cfg_master = 1; ss_i = 1;
        @(negedge clk);
        check(sck_oe && mosi_oe && !miso_oe, "R10 normal master enables",
              {sck_oe, mosi_oe, miso_oe}, 6);
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 4; e++) begin
                logic [7:0] tx, rs;
                cfg_prescale = 3'(p); cfg_exponent = 3'(e);
                cfg_ss_auto  = ((p + e) % 2) == 1;
                cfg_fault_en = cfg_ss_auto;
                tx = 8'(p * 37 + e * 11 + 5);
                rs = 8'((tx * 3) ^ 8'h5A);
                run_master(tx, rs, (p + 1) << e, cfg_ss_auto, 0);
            end
        end
        cfg_ss_auto = 0; cfg_fault_en = 0;
        cfg_prescale = 3'd1; cfg_exponent = 3'd6;
        run_master(8'hC3, 8'h3C, 128, 0, 0);
        cfg_prescale = 3'd0; cfg_exponent = 3'd0;
        run_master(8'h00, 8'hFF, 1, 0, 0);
        run_master(8'hFF, 8'h00, 1, 0, 0);
        run_master(8'h80, 8'h01, 1, 0, 0);

        // single-wire master
        cfg_one_wire = 1; cfg_one_wire_drive = 1;
        @(negedge clk);
        check(mosi_oe == 1 && miso_oe == 0, "R7 single-wire master driving", {mosi_oe, miso_oe}, 2);
        cfg_prescale = 3'd2;
        run_master(8'hA6, 8'h59, 3, 0, 1);
        cfg_one_wire_drive = 0;
        @(negedge clk);
        check(mosi_oe == 0 && miso_oe == 0, "R7 single-wire master reading", {mosi_oe, miso_oe}, 0);
        run_master(8'h1E, 8'hD2, 3, 0, 1);
        cfg_one_wire = 0;

        // mode fault
        cfg_fault_en = 1; cfg_ss_auto = 0; ss_i = 1;
        repeat (3) @(negedge clk);
        ss_i = 0;
        repeat (5) @(negedge clk);
        check(fault_flag == 1, "R5 fault flag set", fault_flag, 1);
        check(sck_oe == 0 && mosi_oe == 0, "R5 clock and data released", {sck_oe, mosi_oe}, 0);
        ss_i = 1;
        repeat (4) @(negedge clk);
        check(fault_flag == 1, "R5 flag sticky", fault_flag, 1);
        cfg_master = 0;
        @(negedge clk);
        cfg_master = 1;
        @(negedge clk);
        check(fault_flag == 0 && sck_oe == 1, "R5 flag cleared by master low", fault_flag, 0);

        // fault suppressed
        cfg_ss_auto = 1;
        ss_i = 0;
        repeat (5) @(negedge clk);
        check(fault_flag == 0 && sck_oe == 1, "R6 no fault with auto SS", fault_flag, 0);
        cfg_ss_auto = 0; cfg_fault_en = 0;
        repeat (5) @(negedge clk);
        check(fault_flag == 0 && sck_oe == 1, "R6 no fault when disabled", fault_flag, 0);
        ss_i = 1;

        // disable
        cfg_enable = 0;
        @(negedge clk);
        check(!sck_oe && !mosi_oe && !miso_oe && !ss_oe, "R11 disabled enables",
              {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);

        // slave modes
        cfg_enable = 1; cfg_master = 0;
        repeat (2) @(negedge clk);
        run_slave(8'hB4, 8'h6D, 0, 0);
        run_slave(8'h0F, 8'hF0, 0, 0);
        cfg_one_wire = 1; cfg_one_wire_drive = 1;
        run_slave(8'h92, 8'h27, 1, 1);
        cfg_one_wire_drive = 0;
        run_slave(8'h55, 8'hAA, 1, 0);

        finish_run();
    end
endmodule